// File: doc/BRIEF.md
# Snooping Three-State Line Coherence Controller

This block holds the coherence state of one cache line in a bus-based multiprocessor that uses snooping and invalidation. Each cycle it sees two kinds of input. The first is the already-decoded local processor requests for the line: read and write. The second is the remote transactions that other caches place on the shared broadcast bus and that hit this line, again split into read and write. It keeps the line in one of three states: invalid, shared or dirty. It issues single-cycle bus action strobes: a data request, an invalidate broadcast and a flush of dirty data.

Tag lookup, the data array, bus arbitration and memory timing all sit outside the block. The bus action strobes are combinational from the registered state and the current inputs, so they appear in the same cycle as the transition that causes them. The new state is visible on `line_state` after the next rising clock edge.

When a snooped transaction and a local request arrive together, the snooped one is applied first. The local request is then judged against the state that results. The state encoding is invalid = 2'b00, shared = 2'b01 and dirty = 2'b10.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset, and for as long as no request arrives, `line_state` reads invalid (2'b00) and all three action strobes are low.
- R2: `line_state` only ever holds 2'b00, 2'b01 or 2'b10.
- R3: A local read while invalid pulses `bus_req` for that cycle only and moves the line to shared.
- R4: A local write while shared pulses `bus_inv` without `bus_req` and moves the line to dirty.
- R5: A local write while invalid is a read-for-ownership. It pulses `bus_req` and `bus_inv` together and moves the line directly to dirty.
- R6: While dirty, with no snooped transaction, local reads and writes keep the line dirty and raise no strobe.
- R7: While shared, a local read raises no strobe and the line stays shared.
- R8: A snooped write moves a shared or dirty line to invalid without a flush. On an invalid line it has no effect.
- R9: A snooped read of a dirty line pulses `bus_flush` and drops the line to shared. A snooped read of a shared or invalid line raises no strobe and leaves the state unchanged.
- R10: When a snooped transaction and a local request coincide, the local request is evaluated against the post-snoop state. For example, on a shared line a snooped write together with a local read gives `bus_req` and ends shared.
- R11: A local write dominates a simultaneous local read, and a snooped write dominates a simultaneous snooped read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| loc_rd | input | 1 | Local processor read hits this line |
| loc_wr | input | 1 | Local processor write hits this line |
| snp_rd | input | 1 | Snooped remote read hits this line |
| snp_wr | input | 1 | Snooped remote write hits this line |
| bus_req | output | 1 | Data request strobe on the bus |
| bus_inv | output | 1 | Invalidate broadcast strobe |
| bus_flush | output | 1 | Write-back of dirty data strobe |
| line_state | output | 2 | Current coherence state of the line |

## Verification
The strobes are due in the same cycle as the stimulus that causes them, because they are combinational from the held state. The bench drives inputs on the falling edge and samples the strobes 2 ns later, before the rising edge. The new state is due one register later, so the bench samples `line_state` 1 ns after the rising edge that follows the stimulus. It clears the inputs on the next falling edge, so each stimulus sees exactly one edge. The sweep covers all sixteen input combinations from each of the three starting states. It compares both the strobes and the next state with a model written from the requirements.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    LINE_INV   = 2'b00,
    LINE_SHR   = 2'b01,
    LINE_DIRTY = 2'b10
  } line_st_e;
endpackage

// File: rtl/coh_rst_sync.sv
module coh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/coh_snoop_stage.sv
module coh_snoop_stage
  import coh_pkg::*;
(
  input  line_st_e st_in,
  input  logic     snp_rd,
  input  logic     snp_wr,
  output line_st_e st_mid,
  output logic     flush
);
  always_comb begin
    st_mid = st_in;
    flush  = 1'b0;
    if (snp_wr) begin
      st_mid = LINE_INV;
    end else if (snp_rd && st_in == LINE_DIRTY) begin
      st_mid = LINE_SHR;
      flush  = 1'b1;
    end
  end
endmodule

// File: rtl/coh_local_stage.sv
module coh_local_stage
  import coh_pkg::*;
(
  input  line_st_e st_mid,
  input  logic     loc_rd,
  input  logic     loc_wr,
  output line_st_e st_nxt,
  output logic     req,
  output logic     inv
);
  always_comb begin
    st_nxt = st_mid;
    req    = 1'b0;
    inv    = 1'b0;
    if (loc_wr) begin
      st_nxt = LINE_DIRTY;
      case (st_mid)
        LINE_INV: begin req = 1'b1; inv = 1'b1; end
        LINE_SHR: inv = 1'b1;
        default:  ;
      endcase
    end else if (loc_rd && st_mid == LINE_INV) begin
      st_nxt = LINE_SHR;
      req    = 1'b1;
    end
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               loc_rd,
  input  logic               loc_wr,
  input  logic               snp_rd,
  input  logic               snp_wr,
  output logic               bus_req,
  output logic               bus_inv,
  output logic               bus_flush,
  output logic [STATE_W-1:0] line_state
);
  logic     rst_n_s;
  line_st_e st_q, st_mid, st_nxt;
  logic     st_en;

  coh_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  coh_snoop_stage u_snoop (
    .st_in(st_q), .snp_rd(snp_rd), .snp_wr(snp_wr),
    .st_mid(st_mid), .flush(bus_flush)
  );

  coh_local_stage u_local (
    .st_mid(st_mid), .loc_rd(loc_rd), .loc_wr(loc_wr),
    .st_nxt(st_nxt), .req(bus_req), .inv(bus_inv)
  );

  assign st_en = (st_nxt != st_q);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   st_q <= LINE_INV;
    else if (st_en) st_q <= st_nxt;
  end

  assign line_state = st_q;

  p_legal_state_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    line_state != 2'b11);

  p_req_fills_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_req |=> line_state != LINE_INV);

  p_inv_owns_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_inv |=> line_state == LINE_DIRTY);

  p_dirty_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (line_state == LINE_DIRTY && !snp_rd && !snp_wr) |-> (!bus_req && !bus_inv && !bus_flush));

  p_snoop_wr_kills_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (snp_wr && !loc_rd && !loc_wr) |=> line_state == LINE_INV);

  p_flush_dirty_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_flush |-> (line_state == LINE_DIRTY && snp_rd && !snp_wr));
endmodule

// File: tb/coh_line_ctrl_tb.sv
module coh_line_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loc_rd = 1'b0, loc_wr = 1'b0, snp_rd = 1'b0, snp_wr = 1'b0;
  logic bus_req, bus_inv, bus_flush;
  logic [1:0] line_state;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  coh_line_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .loc_rd(loc_rd), .loc_wr(loc_wr),
    .snp_rd(snp_rd), .snp_wr(snp_wr), .bus_req(bus_req), .bus_inv(bus_inv),
    .bus_flush(bus_flush), .line_state(line_state)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  function automatic string req_tag(input logic [1:0] s, input logic lr, lw, sr, sw);
    if ((sr || sw) && (lr || lw)) return "R10";
    if (lr && lw) return "R11";
    if (sr && sw) return "R11";
    if (sw) return "R8";
    if (sr) return "R9";
    if (lw) return (s == 2'b00) ? "R5" : (s == 2'b01) ? "R4" : "R6";
    if (lr) return (s == 2'b00) ? "R3" : (s == 2'b01) ? "R7" : "R6";
    return "R1";
  endfunction

  // returns {state[1:0], req, inv, flush}
  function automatic logic [4:0] model(input logic [1:0] s, input logic lr, lw, sr, sw);
    logic [1:0] m;
    logic rq, iv, fl;
    m = s; rq = 0; iv = 0; fl = 0;
    if (sw) m = 2'b00;
    else if (sr && s == 2'b10) begin m = 2'b01; fl = 1; end
    if (lw) begin
      if (m == 2'b00) begin rq = 1; iv = 1; end
      else if (m == 2'b01) iv = 1;
      m = 2'b10;
    end else if (lr && m == 2'b00) begin m = 2'b01; rq = 1; end
    return {m, rq, iv, fl};
  endfunction

  task automatic step(input logic lr, lw, sr, sw, output logic [2:0] acts);
    @(negedge clk);
    loc_rd = lr; loc_wr = lw; snp_rd = sr; snp_wr = sw;
    #2 acts = {bus_req, bus_inv, bus_flush};
    @(negedge clk);
    loc_rd = 0; loc_wr = 0; snp_rd = 0; snp_wr = 0;
  endtask

  task automatic goto(input logic [1:0] s);
    logic [2:0] a;
    step(0, 0, 0, 1, a);
    if (s == 2'b01) step(1, 0, 0, 0, a);
    if (s == 2'b10) step(0, 1, 0, 0, a);
    #1 check($sformatf("R2 setup to %b", s), {line_state, 3'b000}, {s, 3'b000});
  endtask

  initial begin
    logic [2:0] a;
    logic [4:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 check("R1 reset state", {line_state, bus_req, bus_inv, bus_flush}, 5'b00000);
    for (int s = 0; s < 3; s++) begin
      for (int v = 0; v < 16; v++) begin
        goto(2'(s));
        e = model(2'(s), v[3], v[2], v[1], v[0]);
        @(negedge clk);
        loc_rd = v[3]; loc_wr = v[2]; snp_rd = v[1]; snp_wr = v[0];
        #2 a = {bus_req, bus_inv, bus_flush};
        check($sformatf("%s strobes s=%0d in=%b", req_tag(2'(s), v[3], v[2], v[1], v[0]), s, 4'(v)),
              {2'b00, a}, {2'b00, e[2:0]});
        @(posedge clk);
        #1 check($sformatf("%s next s=%0d in=%b", req_tag(2'(s), v[3], v[2], v[1], v[0]), s, 4'(v)),
                 {line_state, 3'b000}, {e[4:3], 3'b000});
        @(negedge clk);
        loc_rd = 0; loc_wr = 0; snp_rd = 0; snp_wr = 0;
        #2 check("R3 strobes drop after one cycle", {2'b00, bus_req, bus_inv, bus_flush},
                 {2'b00, 3'b000});
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule